// File: doc/BRIEF.md
# Indirect Clock-Synthesizer Register Port

This block is a host-side slave. It reaches a bank of byte-wide clock-synthesizer control registers through two byte ports, an index/control port and a data port. A host write to the index port does two things: it selects one register of the bank, and it grants or withdraws permission to write that register. Data-port writes then update the selected register while permission is held. The data-port read output always shows the selected register.

A normal update takes three steps. The host writes the index byte with the permission flag set, writes the data byte, and then writes the index byte again with the flag cleared. A read needs only an index write with the flag clear, after which the host samples the data port.

The bank holds a post-divider register shared by four pixel-clock selects and one feedback-divider register for each select. It also holds an extension register that carries the memory-clock post-divider code and a times-4 feedback flag. A separate 2-bit select register, written through its own port, names the active pixel clock. The block decodes the post-divider field and the feedback divider that belong to that select and presents them on its outputs.

Top module: `pllacc_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bank register, the index byte, the permission flag and the select register are cleared, so every output reads zero after that edge.
- R2: An index-port write stores bits 7:2 as the register index and bit 1 as the write permission. `addr_rd_data` returns {index, permission, 1'b0} from the next cycle, and bit 0 always reads as zero.
- R3: A data-port write while permission is set stores the byte into the selected register. The byte appears on `data_rd_data` in the next cycle, and this holds for every index from 0 up to 63.
- R4: A data-port write while permission is clear changes no register. `data_rd_data` keeps its value.
- R5: After an index-port write, `data_rd_data` shows the contents of the newly selected register from the next cycle on, without altering any register.
- R6: Register index 6 holds four 2-bit post-divider fields, with the field for select n at bits 2n+1:2n. `act_post_div` shows the field for the current select.
- R7: The feedback divider for select n is the register at index 7+n. `act_fb_div` shows the full byte for the current select.
- R8: Register index 11 is the extension register. `mclk_post_code` shows its bits 2:0, and `mclk_fb_x4` shows its bit 3.
- R9: A write on the select port stores the 2-bit value. `sel_q` shows it from the next cycle, and the decoded outputs follow it.
- R10: A data write changes only the register selected at that moment. Every other register keeps its value, and registers never written still read zero.
- R11: When an index write and a data write share a cycle, the data write uses the index and permission that were in force before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_wr_en | input | 1 | Index-port write strobe |
| addr_wr_data | input | 8 | Index byte: index in 7:2, permission in 1, bit 0 ignored |
| addr_rd_data | output | 8 | Index byte readback, bit 0 always zero |
| data_wr_en | input | 1 | Data-port write strobe |
| data_wr_data | input | 8 | Data byte to write |
| data_rd_data | output | 8 | Contents of the selected register |
| sel_wr_en | input | 1 | Select-port write strobe |
| sel_wr_data | input | 2 | Pixel-clock select value |
| sel_q | output | 2 | Current pixel-clock select |
| act_post_div | output | 2 | Post-divider field of the current select |
| act_fb_div | output | 8 | Feedback divider of the current select |
| mclk_post_code | output | 3 | Memory-clock post-divider code |
| mclk_fb_x4 | output | 1 | Times-4 feedback multiplier flag |

## Verification
The properties assume that the strobes are single-cycle, carry known values and change only away from the rising edge. The write-result properties assume that no index write shares a cycle with the data write whose effect they check. To keep within those bounds, the bench drives each strobe on a falling edge and drops it on the next falling edge. It also guards every data-write property with the absence of a same-cycle index write. Only the single directed test for R11 combines the two strobes, and the properties do not cover that case.

// File: rtl/pllacc_pkg.sv
// Package pllacc_pkg
// Shared layout of the index byte and the bank geometry.
// Assumes 8-bit bytes on both host ports.
package pllacc_pkg;
    localparam int BYTE_W  = 8;
    localparam int IDX_LSB = 2;
    localparam int WE_BIT  = 1;
    localparam int IDX_W   = BYTE_W - IDX_LSB;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             we;
    } addr_sel_t;
endpackage

// File: rtl/pllacc_addr_latch.sv
// Module pllacc_addr_latch
// Holds the index and write permission taken from the index port.
// Assumes a single-cycle strobe. Bit 0 of the incoming byte is discarded.
module pllacc_addr_latch
    import pllacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    output addr_sel_t         sel,
    output logic [BYTE_W-1:0] rd_byte
);
    addr_sel_t sel_r;
    logic      unused_bit0;

    // Capture the index and the permission on each index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_r <= '0;
        end else if (wr_en) begin
            sel_r.idx <= wr_byte[BYTE_W-1:IDX_LSB];
            sel_r.we  <= wr_byte[WE_BIT];
        end
    end

    assign unused_bit0 = wr_byte[0];
    assign sel         = sel_r;
    // Reassemble the readback byte with the low bit forced to zero.
    assign rd_byte     = {sel_r.idx, sel_r.we, 1'b0};
endmodule

// File: rtl/pllacc_reg_bank.sv
// Module pllacc_reg_bank
// Byte registers addressed by index. Also provides fixed taps for the
// post-divider, feedback-divider and extension registers.
// Assumes the tap indices lie inside the bank.
module pllacc_reg_bank #(
    parameter int DW          = 8,
    parameter int AW          = 6,
    parameter int NUM_SEL     = 4,
    parameter int POSTDIV_IDX = 6,
    parameter int FBDIV_BASE  = 7,
    parameter int EXT_IDX     = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_idx,
    input  logic [DW-1:0]         wr_data,
    input  logic [AW-1:0]         rd_idx,
    output logic [DW-1:0]         rd_data,
    output logic [DW-1:0]         postdiv_q,
    output logic [NUM_SEL*DW-1:0] fbdiv_q,
    output logic [DW-1:0]         ext_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_reg
            // Load this register when it is the selected write target.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[gi] <= '0;
                else if (wr_en && (wr_idx == AW'(gi)))
                    mem[gi] <= wr_data;
            end
        end
        for (gi = 0; gi < NUM_SEL; gi++) begin : g_fb_tap
            assign fbdiv_q[gi*DW +: DW] = mem[FBDIV_BASE + gi];
        end
    endgenerate

    // Host readback of the selected register.
    assign rd_data   = mem[rd_idx];
    assign postdiv_q = mem[POSTDIV_IDX];
    assign ext_q     = mem[EXT_IDX];
endmodule

// File: rtl/pllacc_clk_decode.sv
// Module pllacc_clk_decode
// Holds the active pixel-clock select and picks that select's post-divider
// field and feedback divider. Also splits out the extension fields.
// Assumes the field for select n sits at bits 2n+1:2n.
module pllacc_clk_decode #(
    parameter int DW      = 8,
    parameter int NUM_SEL = 4,
    parameter int PD_W    = 2,
    parameter int MPD_W   = 3,
    parameter int X4_BIT  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_wr_en,
    input  logic [$clog2(NUM_SEL)-1:0] sel_wr_data,
    input  logic [DW-1:0]              postdiv_q,
    input  logic [NUM_SEL*DW-1:0]      fbdiv_q,
    input  logic [DW-1:0]              ext_q,
    output logic [$clog2(NUM_SEL)-1:0] sel_q,
    output logic [PD_W-1:0]            act_post_div,
    output logic [DW-1:0]              act_fb_div,
    output logic [MPD_W-1:0]           mclk_post_code,
    output logic                       mclk_fb_x4
);
    localparam int SW = $clog2(NUM_SEL);

    logic [SW-1:0]   sel_r;
    logic [PD_W-1:0] pd_field [NUM_SEL];
    logic [DW-1:0]   fb_field [NUM_SEL];
    logic            unused_ext;

    // Latch the active pixel-clock select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_r <= '0;
        else if (sel_wr_en)
            sel_r <= sel_wr_data;
    end

    genvar gs;
    generate
        for (gs = 0; gs < NUM_SEL; gs++) begin : g_split
            assign pd_field[gs] = postdiv_q[gs*PD_W +: PD_W];
            assign fb_field[gs] = fbdiv_q[gs*DW +: DW];
        end
    endgenerate

    // Route the selected fields to the outputs.
    always_comb begin
        act_post_div = pd_field[sel_r];
        act_fb_div   = fb_field[sel_r];
    end

    assign sel_q          = sel_r;
    assign mclk_post_code = ext_q[MPD_W-1:0];
    assign mclk_fb_x4     = ext_q[X4_BIT];
    assign unused_ext     = ^ext_q;
endmodule

// File: rtl/pllacc_port.sv
// Module pllacc_port
// Top level of the indirect clock-synthesizer register port. Connects the
// index latch, the register bank and the clock-select decode.
// Assumes host strobes are one cycle wide. A data write uses the index and
// permission held before its own cycle.
module pllacc_port
    import pllacc_pkg::*;
#(
    parameter int NUM_SEL     = 4,
    parameter int POSTDIV_IDX = 6,
    parameter int FBDIV_BASE  = 7,
    parameter int EXT_IDX     = 11,
    parameter int X4_BIT      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_wr_en,
    input  logic [7:0] addr_wr_data,
    output logic [7:0] addr_rd_data,
    input  logic       data_wr_en,
    input  logic [7:0] data_wr_data,
    output logic [7:0] data_rd_data,
    input  logic       sel_wr_en,
    input  logic [1:0] sel_wr_data,
    output logic [1:0] sel_q,
    output logic [1:0] act_post_div,
    output logic [7:0] act_fb_div,
    output logic [2:0] mclk_post_code,
    output logic       mclk_fb_x4
);
    addr_sel_t                cur_sel;
    logic [BYTE_W-1:0]        postdiv_q;
    logic [BYTE_W-1:0]        ext_q;
    logic [NUM_SEL*BYTE_W-1:0] fbdiv_q;
    logic                     bank_wr;

    pllacc_addr_latch u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (addr_wr_en),
        .wr_byte (addr_wr_data),
        .sel     (cur_sel),
        .rd_byte (addr_rd_data)
    );

    // Gate data writes with the permission flag held before this cycle.
    assign bank_wr = data_wr_en && cur_sel.we;

    pllacc_reg_bank #(
        .DW          (BYTE_W),
        .AW          (IDX_W),
        .NUM_SEL     (NUM_SEL),
        .POSTDIV_IDX (POSTDIV_IDX),
        .FBDIV_BASE  (FBDIV_BASE),
        .EXT_IDX     (EXT_IDX)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bank_wr),
        .wr_idx    (cur_sel.idx),
        .wr_data   (data_wr_data),
        .rd_idx    (cur_sel.idx),
        .rd_data   (data_rd_data),
        .postdiv_q (postdiv_q),
        .fbdiv_q   (fbdiv_q),
        .ext_q     (ext_q)
    );

    pllacc_clk_decode #(
        .DW      (BYTE_W),
        .NUM_SEL (NUM_SEL),
        .PD_W    (2),
        .MPD_W   (3),
        .X4_BIT  (X4_BIT)
    ) u_dec (
        .clk            (clk),
        .rst_n          (rst_n),
        .sel_wr_en      (sel_wr_en),
        .sel_wr_data    (sel_wr_data),
        .postdiv_q      (postdiv_q),
        .fbdiv_q        (fbdiv_q),
        .ext_q          (ext_q),
        .sel_q          (sel_q),
        .act_post_div   (act_post_div),
        .act_fb_div     (act_fb_div),
        .mclk_post_code (mclk_post_code),
        .mclk_fb_x4     (mclk_fb_x4)
    );
endmodule

// File: rtl/pllacc_port_chk.sv
// Module pllacc_port_chk
// Port-level properties of pllacc_port, attached through bind.
// Assumes one-cycle strobes that are driven away from the rising edge.
module pllacc_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       addr_wr_en,
    input logic [7:0] addr_wr_data,
    input logic [7:0] addr_rd_data,
    input logic       data_wr_en,
    input logic [7:0] data_wr_data,
    input logic [7:0] data_rd_data,
    input logic       sel_wr_en,
    input logic [1:0] sel_wr_data,
    input logic [1:0] sel_q,
    input logic [1:0] act_post_div,
    input logic [7:0] act_fb_div,
    input logic [2:0] mclk_post_code,
    input logic       mclk_fb_x4
);
    logic saw_rst = 1'b0;

    // Remember whether the last rising edge sampled reset.
    always_ff @(posedge clk) saw_rst <= !rst_n;

    // R1
    always @(negedge clk) begin
        if (saw_rst)
            reset_clear_chk: assert (addr_rd_data == 8'h00 && data_rd_data == 8'h00 &&
                                     sel_q == 2'd0 && act_fb_div == 8'h00 &&
                                     act_post_div == 2'd0 && mclk_post_code == 3'd0 &&
                                     !mclk_fb_x4);
    end

    // R2
    bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_rd_data[0] == 1'b0);

    // R2
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr_en |=> addr_rd_data == {$past(addr_wr_data[7:1]), 1'b0});

    // R3
    data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_en && addr_rd_data[1] && !addr_wr_en) |=> data_rd_data == $past(data_wr_data));

    // R4
    data_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_en && !addr_rd_data[1] && !addr_wr_en) |=> $stable(data_rd_data));

    // R9
    sel_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr_en |=> sel_q == $past(sel_wr_data));
endmodule

bind pllacc_port pllacc_port_chk u_chk (.*);

// File: tb/pllacc_port_tb.sv
`timescale 1ns/1ps
module pllacc_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_wr_en = 1'b0;
    logic [7:0] addr_wr_data = '0;
    logic [7:0] addr_rd_data;
    logic       data_wr_en = 1'b0;
    logic [7:0] data_wr_data = '0;
    logic [7:0] data_rd_data;
    logic       sel_wr_en = 1'b0;
    logic [1:0] sel_wr_data = '0;
    logic [1:0] sel_q;
    logic [1:0] act_post_div;
    logic [7:0] act_fb_div;
    logic [2:0] mclk_post_code;
    logic       mclk_fb_x4;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pllacc_port u_dut (.*);

    // Table entry: {req[3:0], op[1:0], value[7:0], expect[7:0]}
    // op 0 index write, 1 data write, 2 check data port, 3 check index port
    localparam int NV = 23;
    localparam logic [21:0] VEC [NV] = '{
        {4'd3,  2'd0, 8'h1A, 8'h00},  // R3 select index 6, permission on
        {4'd2,  2'd3, 8'h00, 8'h1A},  // R2 readback
        {4'd3,  2'd1, 8'hE4, 8'h00},  // R3 fields 3,2,1,0
        {4'd3,  2'd2, 8'h00, 8'hE4},  // R3
        {4'd4,  2'd0, 8'h18, 8'h00},  // R4 permission off
        {4'd4,  2'd1, 8'h55, 8'h00},  // R4 ignored write
        {4'd4,  2'd2, 8'h00, 8'hE4},  // R4
        {4'd2,  2'd0, 8'h1F, 8'h00},  // R2 index 7, bit 0 set
        {4'd2,  2'd3, 8'h00, 8'h1E},  // R2 bit 0 reads zero
        {4'd7,  2'd1, 8'h9A, 8'h00},  // R7 feedback select 0
        {4'd7,  2'd2, 8'h00, 8'h9A},  // R7
        {4'd7,  2'd0, 8'h22, 8'h00},  // R7 index 8
        {4'd7,  2'd1, 8'hB7, 8'h00},  // R7 feedback select 1
        {4'd7,  2'd0, 8'h2A, 8'h00},  // R7 index 10
        {4'd7,  2'd1, 8'hFF, 8'h00},  // R7 feedback select 3
        {4'd8,  2'd0, 8'h2E, 8'h00},  // R8 index 11
        {4'd8,  2'd1, 8'h0D, 8'h00},  // R8 code 5, x4 set
        {4'd8,  2'd0, 8'h2C, 8'h00},  // R8 close write
        {4'd8,  2'd2, 8'h00, 8'h0D},  // R8
        {4'd5,  2'd0, 8'h20, 8'h00},  // R5 reselect index 8
        {4'd5,  2'd2, 8'h00, 8'hB7},  // R5
        {4'd10, 2'd0, 8'h24, 8'h00},  // R10 index 9 never written
        {4'd10, 2'd2, 8'h00, 8'h00}   // R10
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic addr_wr(input logic [7:0] b);
        @(negedge clk); addr_wr_en = 1'b1; addr_wr_data = b;
        @(negedge clk); addr_wr_en = 1'b0;
    endtask

    task automatic data_wr(input logic [7:0] b);
        @(negedge clk); data_wr_en = 1'b1; data_wr_data = b;
        @(negedge clk); data_wr_en = 1'b0;
    endtask

    task automatic sel_wr(input logic [1:0] s);
        @(negedge clk); sel_wr_en = 1'b1; sel_wr_data = s;
        @(negedge clk); sel_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic check_decode(input logic [1:0] s, input logic [1:0] pd, input logic [7:0] fb);
        sel_wr(s);
        check("R9 sel_q", {6'd0, sel_q}, {6'd0, s});
        check("R6 act_post_div", {6'd0, act_post_div}, {6'd0, pd});
        check("R7 act_fb_div", act_fb_div, fb);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 addr", addr_rd_data, 8'h00);
        check("R1 data", data_rd_data, 8'h00);
        check("R1 fb", act_fb_div, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq;
            logic [1:0] op;
            logic [7:0] v, e;
            {rq, op, v, e} = VEC[i];
            case (op)
                2'd0: addr_wr(v);
                2'd1: data_wr(v);
                2'd2: check($sformatf("R%0d step %0d", rq, i), data_rd_data, e);
                default: check($sformatf("R%0d step %0d", rq, i), addr_rd_data, e);
            endcase
        end

        // R6 R7 R9 decode for every select
        check_decode(2'd0, 2'd0, 8'h9A);
        check_decode(2'd1, 2'd1, 8'hB7);
        check_decode(2'd2, 2'd2, 8'h00);
        check_decode(2'd3, 2'd3, 8'hFF);
        // R8 extension fields
        check("R8 code", {5'd0, mclk_post_code}, 8'h05);
        check("R8 x4", {7'd0, mclk_fb_x4}, 8'h01);

        // R1 mid-run reset clears everything
        do_reset();
        check("R1 addr after reset", addr_rd_data, 8'h00);
        check("R1 sel after reset", {6'd0, sel_q}, 8'h00);
        check("R1 x4 after reset", {7'd0, mclk_fb_x4}, 8'h00);
        addr_wr(8'h28);
        check("R1 bank after reset", data_rd_data, 8'h00);

        // R3 highest index
        addr_wr(8'hFE);
        data_wr(8'h3C);
        check("R3 index 63", data_rd_data, 8'h3C);

        // R11 same-cycle index and data write
        @(negedge clk);
        addr_wr_en = 1'b1; addr_wr_data = 8'h22;
        data_wr_en = 1'b1; data_wr_data = 8'h11;
        @(negedge clk);
        addr_wr_en = 1'b0; data_wr_en = 1'b0;
        check("R11 new index untouched", data_rd_data, 8'h00);
        addr_wr(8'hFC);
        check("R11 old index written", data_rd_data, 8'h11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule